// File: doc/BRIEF.md
# PHY Bring-up and Link Monitor

This block is a small sequencer that takes an Ethernet PHY from power-on to a monitored link. It issues register accesses through a single request port. Each request is a read or a write, a 5-bit register number and 16 bits of write data. A separate management-bus controller serves the request and answers with a one-cycle done strobe. For reads, that controller also returns the read data with the strobe.

A start pulse begins the bring-up:

- a soft reset of the PHY;
- a wait until the PHY reports that the reset has finished, bounded by a timeout;
- a cleared extended register, reached indirectly through the MMD control and address/data register pair;
- auto-negotiation switched on and restarted, with 100 Mb/s selected.

The sequencer then polls two status registers at a fixed interval. It raises the link flag only when the PHY reports a finished negotiation and a live link at 100 Mb/s full duplex. If the reset never finishes, the sequencer stops in a fault state with an error flag raised. A later start pulse retries the bring-up.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset no request is raised, `link_up_o` and `fault_o` are 0, and nothing happens until `start_i`. The first request after an accepted start is a write of 0x8000 (only bit 15 set) to register 0x00.
- R2: After the reset write the block reads register 0x00 repeatedly while read bit 15 is 1. It moves on after the first read that returns bit 15 as 0.
- R3: The extended clear is exactly four writes, in this order: 0x0003 to register 0x0D, 0x8010 to register 0x0E, 0x4003 to register 0x0D, 0x0000 to register 0x0E.
- R4: Right after the extended clear, register 0x00 is written with 0x3200 (bits 13, 12 and 9 set).
- R5: Polling then repeats a read of register 0x01 followed by a read of register 0x1F. The next 0x01 read request appears between POLL_INTERVAL and POLL_INTERVAL+6 cycles after the done of the previous 0x1F read.
- R6: `link_up_o` is 1 only when all four conditions hold:
  - register 0x01 bit 5 is set;
  - register 0x01 bit 2 is set;
  - register 0x1F bit 12 is set;
  - register 0x1F bits [4:2] equal 3'b110.

  Every other value of bits [4:2] (for example 001, 101 or 010) gives 0.
- R7: `link_up_o` is a register. It changes only after a 0x1F read of a poll completes (or when it is cleared by a start or a fault).
- R8: Only one request is outstanding at a time. While `req_valid_o` is high without `req_done_i`, the write flag, register and write data stay unchanged. `req_valid_o` drops in the cycle after `req_done_i`.
- R9: If register 0x00 still reports bit 15 set once RESET_TIMEOUT cycles have passed in the reset wait, the block does three things:
  - it raises `fault_o`;
  - it clears `link_up_o`;
  - it stops issuing requests.

  A start pulse in the fault state clears `fault_o` and restarts the bring-up.
- R10: `start_i` is ignored while bring-up or polling is in progress; it neither restarts the sequence nor alters the access order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle or faulted |
| req_valid_o | output | 1 | Access request pending |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_reg_o | output | 5 | PHY register number |
| req_wdata_o | output | 16 | Write data |
| req_done_i | input | 1 | One-cycle completion strobe from the management controller |
| req_rdata_i | input | 16 | Read data, valid with `req_done_i` |
| link_up_o | output | 1 | 100 Mb/s full-duplex link present |
| fault_o | output | 1 | Reset-wait timeout occurred |

## Verification
A bus model answers each request after a random delay of zero to three cycles. It logs every access, so the exact bring-up order is compared against the expected sequence, with a reset that stays busy for several reads. Directed status values probe each speed/duplex code and each missing qualifying bit separately, so that every term of the link condition has to matter on its own. Random status words, biased toward the qualifying bits, then test combinations of those terms against a bench-computed expectation. A PHY whose reset never clears tells the timeout path apart from the normal path, and a start pulse while polling shows that an active sequence ignores it.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  // PHY register numbers used by the sequence
  localparam logic [4:0] REG_CTRL     = 5'h00;
  localparam logic [4:0] REG_STAT     = 5'h01;
  localparam logic [4:0] REG_MMD_CTL  = 5'h0D;
  localparam logic [4:0] REG_MMD_DATA = 5'h0E;
  localparam logic [4:0] REG_VSTAT    = 5'h1F;

  // Write values
  localparam logic [15:0] CTRL_SOFT_RST = 16'h8000;
  localparam logic [15:0] CTRL_AUTONEG  = 16'h3200;
  localparam logic [15:0] MMD_SEL_ADDR  = 16'h0003;
  localparam logic [15:0] MMD_SEL_DATA  = 16'h4003;

  // Bit positions inspected in read data
  localparam int CTRL_RST_BIT    = 15;
  localparam int STAT_AN_OK_BIT  = 5;
  localparam int STAT_LINK_BIT   = 2;
  localparam int VSTAT_AN_OK_BIT = 12;
  localparam logic [2:0] MODE_100_FULL = 3'b110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WR,
    ST_RST_RD,
    ST_MMD_CTL_A,
    ST_MMD_ADDR,
    ST_MMD_CTL_D,
    ST_MMD_DATA,
    ST_AN_EN,
    ST_POLL_WAIT,
    ST_RD_STAT,
    ST_RD_VSTAT,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic        write;
    logic [4:0]  regno;
    logic [15:0] wdata;
  } acc_cmd_t;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/phy_seq_access.sv
module phy_seq_access
  import phy_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        issue_i,
  input  acc_cmd_t    cmd_i,
  output logic        req_valid_o,
  output logic        req_write_o,
  output logic [4:0]  req_reg_o,
  output logic [15:0] req_wdata_o,
  input  logic        req_done_i,
  input  logic [15:0] req_rdata_i,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_o <= 1'b0;
      req_write_o <= 1'b0;
      req_reg_o   <= '0;
      req_wdata_o <= '0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (req_valid_o && req_done_i) begin
        req_valid_o <= 1'b0;
        done_o      <= 1'b1;
        rdata_o     <= req_rdata_i;
      end else if (issue_i && !req_valid_o) begin
        req_valid_o <= 1'b1;
        req_write_o <= cmd_i.write;
        req_reg_o   <= cmd_i.regno;
        req_wdata_o <= cmd_i.wdata;
      end
    end
  end
endmodule

// File: rtl/phy_seq_link_qual.sv
module phy_seq_link_qual
  import phy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       update_i,
  input  logic       stat_an_ok_i,
  input  logic       stat_link_i,
  input  logic       vstat_an_ok_i,
  input  logic [2:0] vstat_mode_i,
  output logic       link_up_o
);
  logic qualified;

  assign qualified = stat_an_ok_i && stat_link_i && vstat_an_ok_i &&
                     (vstat_mode_i == MODE_100_FULL);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      link_up_o <= 1'b0;
    end else if (update_i) begin
      link_up_o <= qualified;
    end
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int          POLL_INTERVAL = 100000,
  parameter int          RESET_TIMEOUT = 1000000,
  parameter logic [15:0] EXT_ADDR      = 16'h8010,
  parameter logic [15:0] EXT_DATA      = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  output logic        req_valid_o,
  output logic        req_write_o,
  output logic [4:0]  req_reg_o,
  output logic [15:0] req_wdata_o,
  input  logic        req_done_i,
  input  logic [15:0] req_rdata_i,
  output logic        link_up_o,
  output logic        fault_o
);
  seq_state_e  state_q;
  logic        pend_q;
  logic        fault_q;
  logic [1:0]  stat_bits_q;   // {auto-neg done, link} from register 0x01
  acc_cmd_t    cmd;
  logic        is_access;
  logic        acc_issue;
  logic        acc_done;
  logic [15:0] acc_rdata;
  logic        poll_exp;
  logic        rst_exp;
  logic        start_ok;
  logic        rst_busy;
  logic        go_fault;
  logic        link_upd;
  logic        link_clr;
  logic        unused_rdata;

  assign unused_rdata = ^{acc_rdata[14:13], acc_rdata[11:6], acc_rdata[1:0]};

  // Command for each access step
  always_comb begin
    cmd = '{write: 1'b0, regno: REG_CTRL, wdata: 16'h0000};
    is_access = 1'b1;
    case (state_q)
      ST_RST_WR:    cmd = '{write: 1'b1, regno: REG_CTRL,     wdata: CTRL_SOFT_RST};
      ST_RST_RD:    cmd = '{write: 1'b0, regno: REG_CTRL,     wdata: 16'h0000};
      ST_MMD_CTL_A: cmd = '{write: 1'b1, regno: REG_MMD_CTL,  wdata: MMD_SEL_ADDR};
      ST_MMD_ADDR:  cmd = '{write: 1'b1, regno: REG_MMD_DATA, wdata: EXT_ADDR};
      ST_MMD_CTL_D: cmd = '{write: 1'b1, regno: REG_MMD_CTL,  wdata: MMD_SEL_DATA};
      ST_MMD_DATA:  cmd = '{write: 1'b1, regno: REG_MMD_DATA, wdata: EXT_DATA};
      ST_AN_EN:     cmd = '{write: 1'b1, regno: REG_CTRL,     wdata: CTRL_AUTONEG};
      ST_RD_STAT:   cmd = '{write: 1'b0, regno: REG_STAT,     wdata: 16'h0000};
      ST_RD_VSTAT:  cmd = '{write: 1'b0, regno: REG_VSTAT,    wdata: 16'h0000};
      default:      is_access = 1'b0;
    endcase
  end

  assign acc_issue = is_access && !pend_q;
  assign start_ok  = start_i && (state_q == ST_IDLE || state_q == ST_FAULT);
  assign rst_busy  = acc_rdata[CTRL_RST_BIT];
  assign go_fault  = (state_q == ST_RST_RD) && acc_done && rst_busy && rst_exp;
  assign link_upd  = (state_q == ST_RD_VSTAT) && acc_done;
  assign link_clr  = start_ok || go_fault;

  phy_seq_access u_access (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (acc_issue),
    .cmd_i       (cmd),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_reg_o   (req_reg_o),
    .req_wdata_o (req_wdata_o),
    .req_done_i  (req_done_i),
    .req_rdata_i (req_rdata_i),
    .done_o      (acc_done),
    .rdata_o     (acc_rdata)
  );

  phy_seq_timer #(.LIMIT(POLL_INTERVAL)) u_poll_tmr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (state_q != ST_POLL_WAIT),
    .expired_o (poll_exp)
  );

  phy_seq_timer #(.LIMIT(RESET_TIMEOUT)) u_rst_tmr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (state_q != ST_RST_RD),
    .expired_o (rst_exp)
  );

  phy_seq_link_qual u_link (
    .clk           (clk),
    .rst           (rst),
    .clear_i       (link_clr),
    .update_i      (link_upd),
    .stat_an_ok_i  (stat_bits_q[1]),
    .stat_link_i   (stat_bits_q[0]),
    .vstat_an_ok_i (acc_rdata[VSTAT_AN_OK_BIT]),
    .vstat_mode_i  (acc_rdata[4:2]),
    .link_up_o     (link_up_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pend_q      <= 1'b0;
      fault_q     <= 1'b0;
      stat_bits_q <= '0;
    end else begin
      if (acc_issue) pend_q <= 1'b1;
      if (acc_done)  pend_q <= 1'b0;
      case (state_q)
        ST_IDLE, ST_FAULT: begin
          if (start_ok) begin
            state_q <= ST_RST_WR;
            fault_q <= 1'b0;
          end
        end
        ST_POLL_WAIT: if (poll_exp) state_q <= ST_RD_STAT;
        ST_RST_WR:    if (acc_done) state_q <= ST_RST_RD;
        ST_RST_RD: begin
          if (acc_done) begin
            if (!rst_busy) begin
              state_q <= ST_MMD_CTL_A;
            end else if (rst_exp) begin
              state_q <= ST_FAULT;
              fault_q <= 1'b1;
            end
          end
        end
        ST_MMD_CTL_A: if (acc_done) state_q <= ST_MMD_ADDR;
        ST_MMD_ADDR:  if (acc_done) state_q <= ST_MMD_CTL_D;
        ST_MMD_CTL_D: if (acc_done) state_q <= ST_MMD_DATA;
        ST_MMD_DATA:  if (acc_done) state_q <= ST_AN_EN;
        ST_AN_EN:     if (acc_done) state_q <= ST_POLL_WAIT;
        ST_RD_STAT: begin
          if (acc_done) begin
            stat_bits_q <= {acc_rdata[STAT_AN_OK_BIT], acc_rdata[STAT_LINK_BIT]};
            state_q     <= ST_RD_VSTAT;
          end
        end
        ST_RD_VSTAT:  if (acc_done) state_q <= ST_POLL_WAIT;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid_o,
  input logic        req_write_o,
  input logic [4:0]  req_reg_o,
  input logic [15:0] req_wdata_o,
  input logic        req_done_i,
  input logic        link_up_o,
  input logic        fault_o,
  input logic        link_upd,
  input logic        link_clr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_done_i) |=> (req_valid_o && $stable(req_write_o) && $stable(req_reg_o) && $stable(req_wdata_o))); // R8

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && req_done_i) |=> !req_valid_o); // R8

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!link_upd && !link_clr) |=> $stable(link_up_o)); // R7

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!req_valid_o && !link_up_o)); // R9
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_o (req_valid_o),
  .req_write_o (req_write_o),
  .req_reg_o   (req_reg_o),
  .req_wdata_o (req_wdata_o),
  .req_done_i  (req_done_i),
  .link_up_o   (link_up_o),
  .fault_o     (fault_o),
  .link_upd    (link_upd),
  .link_clr    (link_clr)
);

// File: tb/phy_bringup_seq_bench.sv
module phy_bringup_seq_bench;
  localparam int PI = 24;
  localparam int TO = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_valid, req_write;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        req_done = 1'b0;
  logic [15:0] req_rdata = '0;
  logic        link_up, fault;

  always #5 clk = ~clk;

  phy_bringup_seq #(.POLL_INTERVAL(PI), .RESET_TIMEOUT(TO)) u_phy_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start),
    .req_valid_o(req_valid), .req_write_o(req_write), .req_reg_o(req_reg),
    .req_wdata_o(req_wdata), .req_done_i(req_done), .req_rdata_i(req_rdata),
    .link_up_o(link_up), .fault_o(fault)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // PHY register model and bus responder
  int          busy_cfg = 3;
  int          busy_left = 0;
  logic [15:0] stat_v = '0;
  logic [15:0] vstat_v = '0;
  int          wait_left = 0;
  bit          active = 0;
  logic        h_w;
  logic [4:0]  h_reg;
  logic [15:0] h_d;
  logic        log_w [64];
  logic [4:0]  log_reg [64];
  logic [15:0] log_d [64];
  int          log_n = 0;
  int          vstat_cnt = 0;
  int          last_stat = 0;
  int          order_err = 0, stab_err = 0, gap_err = 0, gap_n = 0;
  int          vstat_cyc = -1;

  always @(negedge clk) begin
    if (rst) begin
      req_done = 1'b0;
      active = 0;
    end else if (req_done) begin
      req_done = 1'b0;
    end else if (req_valid) begin
      if (!active) begin
        active = 1;
        h_w = req_write; h_reg = req_reg; h_d = req_wdata;
        wait_left = $urandom % 4;
        if (!req_write && req_reg == 5'h01 && vstat_cyc >= 0) begin
          gap_n++;
          if (cyc - vstat_cyc < PI || cyc - vstat_cyc > PI + 6) gap_err++;
        end
      end else if ({req_write, req_reg, req_wdata} != {h_w, h_reg, h_d}) begin
        stab_err++;
      end
      if (wait_left == 0) begin
        req_rdata = 16'h0000;
        if (req_write) begin
          if (req_reg == 5'h00 && req_wdata[15]) begin
            busy_left = busy_cfg; last_stat = 0; vstat_cyc = -1;
          end
        end else begin
          case (req_reg)
            5'h00: begin
              req_rdata = (busy_left > 0) ? 16'h8000 : 16'h3000;
              if (busy_left > 0) busy_left--;
            end
            5'h01: begin
              if (last_stat == 1) order_err++;
              last_stat = 1;
              req_rdata = stat_v;
            end
            5'h1F: begin
              if (last_stat != 1) order_err++;
              last_stat = 0;
              req_rdata = vstat_v;
              vstat_cnt++;
              vstat_cyc = cyc;
            end
            default: req_rdata = 16'h0000;
          endcase
        end
        if (log_n < 64) begin
          log_w[log_n] = req_write; log_reg[log_n] = req_reg; log_d[log_n] = req_wdata;
          log_n++;
        end
        req_done = 1'b1;
        active = 0;
      end else begin
        wait_left--;
      end
    end
  end

  function automatic bit link_expect(logic [15:0] s, logic [15:0] v);
    return s[5] && s[2] && v[12] && (v[4:2] == 3'b110);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_polls(int n);
    int base = vstat_cnt;
    int g = 0;
    while (vstat_cnt < base + n && g < 3000) begin
      @(negedge clk);
      g++;
    end
    if (g >= 3000) check(0, "R5", "poll progress", vstat_cnt, base + n);
    repeat (4) @(negedge clk);
  endtask

  task automatic link_case(logic [15:0] s, logic [15:0] v, string what);
    stat_v = s; vstat_v = v;
    wait_polls(2);
    check(link_up == link_expect(s, v), "R6", what, link_up, link_expect(s, v));
  endtask

  initial begin
    wait (cyc >= 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic        ew [12];
    logic [4:0]  er [12];
    logic [15:0] ed [12];
    int          g;
    int          nreq;
    void'($urandom(32'h5A17));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and idle without start
    check(!req_valid && !link_up && !fault, "R1", "reset state",
          {req_valid, link_up, fault}, 0);
    nreq = 0;
    repeat (10) begin @(negedge clk); if (req_valid) nreq++; end
    check(nreq == 0, "R1", "no request before start", nreq, 0);

    // Bring-up with a reset busy for three reads
    busy_cfg = 3;
    log_n = 0;
    pulse_start();
    g = 0;
    while (log_n < 12 && g < 3000) begin @(negedge clk); g++; end
    ew = '{1,0,0,0,0,1,1,1,1,1,0,0};
    er = '{5'h00,5'h00,5'h00,5'h00,5'h00,5'h0D,5'h0E,5'h0D,5'h0E,5'h00,5'h01,5'h1F};
    ed = '{16'h8000,0,0,0,0,16'h0003,16'h8010,16'h4003,16'h0000,16'h3200,0,0};
    check(log_w[0] == 1'b1 && log_reg[0] == 5'h00 && log_d[0] == 16'h8000, "R1",
          "first access reset write", log_d[0], 16'h8000);
    for (int i = 1; i < 5; i++)
      check(!log_w[i] && log_reg[i] == 5'h00, "R2", "reset poll read",
            {log_w[i], log_reg[i]}, 0);
    for (int i = 5; i < 9; i++)
      check(log_w[i] == ew[i] && log_reg[i] == er[i] && log_d[i] == ed[i], "R3",
            "extended write step", {log_reg[i], log_d[i]}, {er[i], ed[i]});
    check(log_w[9] && log_reg[9] == 5'h00 && log_d[9] == 16'h3200, "R4",
          "auto-negotiation enable write", {log_reg[9], log_d[9]}, 16'h3200);
    check(!log_w[10] && log_reg[10] == 5'h01 && !log_w[11] && log_reg[11] == 5'h1F, "R5",
          "first poll order", {log_reg[10], log_reg[11]}, {5'h01, 5'h1F});

    // R10: start while polling is ignored
    log_n = 0;
    pulse_start();
    g = 0;
    while (log_n < 4 && g < 3000) begin @(negedge clk); g++; end
    nreq = 0;
    for (int i = 0; i < 4; i++) if (log_w[i]) nreq++;
    check(nreq == 0 && log_n >= 4, "R10", "start during polling ignored", nreq, 0);

    // R6: directed cases
    link_case(16'h0024, 16'h1018, "100 full qualified");
    link_case(16'h0024, 16'h1004, "10 half code 001");
    link_case(16'h0024, 16'h1014, "10 full code 101");
    link_case(16'h0024, 16'h1008, "100 half code 010");
    link_case(16'h0004, 16'h1018, "status autoneg bit clear");
    link_case(16'h0020, 16'h1018, "status link bit clear");
    link_case(16'h0024, 16'h0018, "vendor autoneg bit clear");

    // R7: link holds between status completions
    link_case(16'hFFFF, 16'h1018, "all status bits set");
    g = vstat_cnt;
    while (vstat_cnt == g) @(negedge clk);
    repeat (5) @(negedge clk);
    stat_v = 16'h0000;
    repeat (PI / 2) @(negedge clk);
    check(link_up == 1'b1, "R7", "link held before next poll", link_up, 1);
    wait_polls(2);
    check(link_up == 1'b0, "R7", "link drops after poll", link_up, 0);

    // R6: random status words
    for (int t = 0; t < 30; t++) begin
      logic [15:0] s, v;
      s = 16'($urandom);
      v = 16'($urandom);
      if ($urandom % 2) s = s | 16'h0024;
      if ($urandom % 2) v = v | 16'h1000;
      if ($urandom % 2) v = (v & ~16'h001C) | 16'h0018;
      link_case(s, v, "random status");
    end

    check(order_err == 0, "R5", "read order 0x01 then 0x1F", order_err, 0);
    check(gap_err == 0 && gap_n > 0, "R5", "poll interval window", gap_err, 0);
    check(stab_err == 0, "R8", "request fields stable", stab_err, 0);

    // R9: reset never finishes
    stat_v = 16'h0024; vstat_v = 16'h1018;
    wait_polls(2);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    busy_cfg = 1 << 30;
    pulse_start();
    g = 0;
    while (!fault && g < 3000) begin @(negedge clk); g++; end
    check(fault == 1'b1, "R9", "fault after timeout", fault, 1);
    check(g >= TO - 10, "R9", "fault not early", g, TO);
    check(link_up == 1'b0, "R9", "link low in fault", link_up, 0);
    nreq = 0;
    repeat (50) begin @(negedge clk); if (req_valid) nreq++; end
    check(nreq == 0, "R9", "no requests in fault", nreq, 0);
    busy_cfg = 1;
    pulse_start();
    repeat (2) @(negedge clk);
    check(fault == 1'b0, "R9", "start clears fault", fault, 0);
    wait_polls(2);
    check(link_up == 1'b1, "R9", "restart reaches polling", link_up, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule